// File: doc/BRIEF.md
# Privacy cache hit resolver

This block sits beside a cache tag array and settles whether a lookup is a hit. For lines from a sealed memory space, it also settles whether the requester may see the data as plaintext or only as ciphertext. A plain tag compare is not enough once a line is sealed. The answer then depends on who issues the access (hypervisor, guest kernel or application context), on which VM, process and sealed context own the line, and on a per-word bit that the owning application sets to let its guest kernel read that word.

The cache controller presents one lookup per cycle. A lookup carries a request strobe, the byte address within the line, the result of the ordinary tag compare, the extended tag fields of the candidate line, the five status values of the issuing agent, and a flag saying whether the requester's data key equals the line owner's data key. One cycle later the resolver returns three results. The first is hit or miss. The second is a deny flag, raised when a sealed line may only be delivered encrypted. The third is the format (plaintext or ciphertext) in which the line must be held to serve this requester, which is also the format to use on a refill. When the stored format differs from that entitlement, the lookup is a miss, so the line is fetched again in the correct form.

Top module: `pcr_resolver`

## Requirements
- R1: While `rst` is high, and on the cycle after it was high, `rsp_valid`, `rsp_hit`, `rsp_deny` and `rsp_plain` are all 0.
- R2: `rsp_valid` is 1 exactly on the cycle after a cycle in which `req_valid` was 1. When `rsp_valid` is 0, `rsp_hit`, `rsp_deny` and `rsp_plain` are 0.
- R3: For a line with `ln_sealed`=0, the response has `rsp_hit` equal to the sampled `tag_match`, `rsp_plain`=1 and `rsp_deny`=0, whatever the status inputs are.
- R4: A lookup with `tag_match`=0 never yields `rsp_hit`=1.
- R5: An application access (`st_hyp`=0, `st_kern`=0) to a sealed line whose `ln_ctx`, `ln_pid` and `ln_vm` all equal `st_ctx`, `st_pid` and `st_vm` is entitled to plaintext (`rsp_plain`=1, `rsp_deny`=0).
- R6: An application access to a sealed line owned by another context is entitled to plaintext when `key_same`=1. Otherwise it gets ciphertext with `rsp_deny`=1 and `rsp_plain`=0.
- R7: A sealed line with `ln_pid`=0 belongs to the guest kernel of `ln_vm`. A guest-kernel access (`st_hyp`=0, `st_kern`=1) whose `st_vm` and `st_ctx` match such a line's `ln_vm` and `ln_ctx` is entitled to plaintext.
- R8: A guest-kernel access to a sealed application line (`ln_pid`≠0) of its own VM is entitled to plaintext only if `ln_vis[i]`=1, where i = `req_addr[5:2]` (bit i covers the 4-byte word i of the 64-byte line). Otherwise it gets ciphertext with `rsp_deny`=1.
- R9: A hypervisor access (`st_hyp`=1) to any sealed line gets ciphertext (`rsp_plain`=0, `rsp_deny`=1). This holds even when `st_kern` or `key_same` is also 1.
- R10: When `tag_match`=1 on a sealed line, `rsp_hit`=1 only if `ln_plain` equals the entitled format. On a mismatch the lookup is a miss, and `rsp_plain` still reports the entitled format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Access byte address; bits [5:2] pick the word |
| tag_match | input | 1 | Result of the ordinary address tag compare |
| ln_sealed | input | 1 | Line comes from a sealed memory space |
| ln_plain | input | 1 | Line is stored decrypted (1) or encrypted (0) |
| ln_ctx | input | 7 | Owning sealed-context index |
| ln_pid | input | 6 | Owning process index, 0 for guest-kernel space |
| ln_vm | input | 6 | Owning VM ID |
| ln_vis | input | 16 | Per-word guest-kernel visibility bits |
| st_hyp | input | 1 | Requester runs in hypervisor mode |
| st_kern | input | 1 | Requester runs in guest-kernel mode |
| st_vm | input | 6 | Requester's current VM ID |
| st_pid | input | 6 | Requester's current process index |
| st_ctx | input | 7 | Active sealed-context register |
| key_same | input | 1 | Requester and line owner share a data key |
| rsp_valid | output | 1 | Result valid, one cycle after `req_valid` |
| rsp_hit | output | 1 | Lookup counts as a hit |
| rsp_deny | output | 1 | Sealed line may be delivered only encrypted |
| rsp_plain | output | 1 | Format needed: 1 plaintext, 0 ciphertext |

## Verification
Some properties are checked by assertions on every cycle: the fixed one-cycle response timing, quiet outputs when there is no lookup, no hit without a tag match, the plain behaviour of unsealed lines, and ciphertext-only delivery to the hypervisor, including the forced miss when a hypervisor finds a decrypted copy. Other cases need a chosen line and a chosen requester, and only the bench scenarios show them. These are ownership by application and by guest kernel, the shared-key exception, word-level visibility selected by the address, and the format-mismatch miss for the other requester kinds. The scoreboard predicts each of these from the requirement rules.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int CTX_W      = 7;
    localparam int PID_W      = 6;
    localparam int VM_W       = 6;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 64;
    localparam int WORD_BYTES = 4;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WIDX_W     = $clog2(WORDS);
    localparam int WOFS       = $clog2(WORD_BYTES);

    // Extended tag of one cache line
    typedef struct packed {
        logic             sealed;
        logic             plain;
        logic [CTX_W-1:0] ctx;
        logic [PID_W-1:0] pid;
        logic [VM_W-1:0]  vm;
        logic [WORDS-1:0] vis;
    } line_tag_t;

    // Status of the agent issuing the access
    typedef struct packed {
        logic             hyp;
        logic             kern;
        logic [VM_W-1:0]  vm;
        logic [PID_W-1:0] pid;
        logic [CTX_W-1:0] ctx;
    } who_t;

    typedef enum logic [1:0] {
        ACT_APP  = 2'd0,
        ACT_KERN = 2'd1,
        ACT_HYP  = 2'd2
    } actor_e;

    typedef struct packed {
        logic valid;
        logic hit;
        logic deny;
        logic plain;
    } verdict_t;

    // Hypervisor mode outranks guest-kernel mode
    function automatic actor_e classify(input logic hyp, input logic kern);
        if (hyp)       return ACT_HYP;
        else if (kern) return ACT_KERN;
        else           return ACT_APP;
    endfunction
endpackage

// File: rtl/pcr_vis_pick.sv
module pcr_vis_pick
    import pcr_pkg::*;
(
    input  logic [WORDS-1:0]  vis,
    input  logic [WIDX_W-1:0] widx,
    output logic              bit_set
);
    logic [WORDS-1:0] sel;

    // One-hot word decode, then AND-OR with the visibility vector
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign sel[g] = (widx == WIDX_W'(g)) & vis[g];
    end

    assign bit_set = |sel;
endmodule

// File: rtl/pcr_policy.sv
module pcr_policy
    import pcr_pkg::*;
(
    input  line_tag_t line,
    input  who_t      who,
    input  logic      vis_bit,
    input  logic      key_same,
    output logic      ent_plain
);
    actor_e act;
    logic   same_vm;
    logic   kern_line;
    logic   own_app;
    logic   own_kern;

    assign act       = classify(who.hyp, who.kern);
    assign same_vm   = (line.vm == who.vm);
    assign kern_line = (line.pid == '0);
    assign own_app   = same_vm && (line.pid == who.pid) && (line.ctx == who.ctx);
    assign own_kern  = same_vm && kern_line && (line.ctx == who.ctx);

    always_comb begin
        if (!line.sealed) begin
            ent_plain = 1'b1;
        end else begin
            unique case (act)
                ACT_HYP:  ent_plain = 1'b0;
                ACT_KERN: ent_plain = own_kern || (!kern_line && same_vm && vis_bit);
                ACT_APP:  ent_plain = own_app || key_same;
                default:  ent_plain = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pcr_rsp_reg.sv
module pcr_rsp_reg
    import pcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t d,
    output verdict_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pcr_resolver.sv
module pcr_resolver
    import pcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              tag_match,
    input  logic              ln_sealed,
    input  logic              ln_plain,
    input  logic [CTX_W-1:0]  ln_ctx,
    input  logic [PID_W-1:0]  ln_pid,
    input  logic [VM_W-1:0]   ln_vm,
    input  logic [WORDS-1:0]  ln_vis,
    input  logic              st_hyp,
    input  logic              st_kern,
    input  logic [VM_W-1:0]   st_vm,
    input  logic [PID_W-1:0]  st_pid,
    input  logic [CTX_W-1:0]  st_ctx,
    input  logic              key_same,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_deny,
    output logic              rsp_plain
);
    line_tag_t         line;
    who_t              who;
    logic [WIDX_W-1:0] widx;
    logic              vis_bit;
    logic              ent_plain;
    verdict_t          nxt;
    verdict_t          cur;
    logic              unused_addr_bits;

    assign line = '{sealed: ln_sealed, plain: ln_plain, ctx: ln_ctx,
                    pid: ln_pid, vm: ln_vm, vis: ln_vis};
    assign who  = '{hyp: st_hyp, kern: st_kern, vm: st_vm,
                    pid: st_pid, ctx: st_ctx};

    assign widx             = req_addr[WOFS +: WIDX_W];
    assign unused_addr_bits = ^{req_addr[ADDR_W-1:WOFS+WIDX_W], req_addr[WOFS-1:0]};

    pcr_vis_pick u_pick (
        .vis     (ln_vis),
        .widx    (widx),
        .bit_set (vis_bit)
    );

    pcr_policy u_pol (
        .line      (line),
        .who       (who),
        .vis_bit   (vis_bit),
        .key_same  (key_same),
        .ent_plain (ent_plain)
    );

    always_comb begin
        nxt       = '0;
        nxt.valid = req_valid;
        if (req_valid) begin
            nxt.plain = ent_plain;
            nxt.deny  = ln_sealed && !ent_plain;
            nxt.hit   = tag_match && (!ln_sealed || (ln_plain == ent_plain));
        end
    end

    pcr_rsp_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign rsp_valid = cur.valid;
    assign rsp_hit   = cur.hit;
    assign rsp_deny  = cur.deny;
    assign rsp_plain = cur.plain;
endmodule

// File: rtl/pcr_resolver_chk.sv
module pcr_resolver_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic tag_match,
    input logic ln_sealed,
    input logic ln_plain,
    input logic st_hyp,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_deny,
    input logic rsp_plain
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_hit && !rsp_deny && !rsp_plain));

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_deny && !rsp_plain));

    // R4
    no_hit_wo_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !tag_match) |=> !rsp_hit);

    // R3
    unsealed_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ln_sealed) |=>
            (rsp_plain && !rsp_deny && (rsp_hit == $past(tag_match))));

    // R9
    hyp_cipher_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ln_sealed && st_hyp) |=> (!rsp_plain && rsp_deny));

    // R10
    hyp_plain_copy_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ln_sealed && st_hyp && ln_plain) |=> !rsp_hit);
endmodule

bind pcr_resolver pcr_resolver_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .tag_match (tag_match),
    .ln_sealed (ln_sealed),
    .ln_plain  (ln_plain),
    .st_hyp    (st_hyp),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_deny  (rsp_deny),
    .rsp_plain (rsp_plain)
);

// File: tb/sim_pcr_resolver.sv
module sim_pcr_resolver;
    import pcr_pkg::*;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              tag_match = 1'b0;
    logic              ln_sealed = 1'b0, ln_plain = 1'b0;
    logic [CTX_W-1:0]  ln_ctx = '0;
    logic [PID_W-1:0]  ln_pid = '0;
    logic [VM_W-1:0]   ln_vm = '0;
    logic [WORDS-1:0]  ln_vis = '0;
    logic              st_hyp = 1'b0, st_kern = 1'b0;
    logic [VM_W-1:0]   st_vm = '0;
    logic [PID_W-1:0]  st_pid = '0;
    logic [CTX_W-1:0]  st_ctx = '0;
    logic              key_same = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_deny, rsp_plain;

    int total = 0;
    int bad   = 0;

    typedef struct {
        verdict_t v;
        string    tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    pcr_resolver u0 (.*);

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected verdict from the requirement rules
    function automatic verdict_t predict(line_tag_t l, who_t w, logic tm, logic keq,
                                         logic [ADDR_W-1:0] a);
        verdict_t r;
        logic     ent;
        if (!l.sealed)    ent = 1'b1;                                   // R3
        else if (w.hyp)   ent = 1'b0;                                   // R9
        else if (w.kern)  ent = (l.pid == 0 && l.vm == w.vm && l.ctx == w.ctx)   // R7
                              || (l.pid != 0 && l.vm == w.vm && l.vis[a[5:2]]); // R8
        else              ent = (l.ctx == w.ctx && l.pid == w.pid && l.vm == w.vm) // R5
                              || keq;                                   // R6
        r.valid = 1'b1;
        r.plain = ent;
        r.deny  = l.sealed && !ent;
        r.hit   = tm && (!l.sealed || l.plain == ent);                  // R4, R10
        return r;
    endfunction

    task automatic issue(input line_tag_t l, input who_t w, input logic tm, input logic keq,
                         input logic [ADDR_W-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; tag_match = tm; key_same = keq;
        ln_sealed = l.sealed; ln_plain = l.plain; ln_ctx = l.ctx;
        ln_pid = l.pid; ln_vm = l.vm; ln_vis = l.vis;
        st_hyp = w.hyp; st_kern = w.kern; st_vm = w.vm; st_pid = w.pid; st_ctx = w.ctx;
        e.v = predict(l, w, tm, keq, a);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0;
        tag_match = 1'b1;
        ln_sealed = 1'b0;
        e.v = '0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares each result just after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "valid", rsp_valid, e.v.valid);
                check(e.tag, "hit",   rsp_hit,   e.v.hit);
                check(e.tag, "deny",  rsp_deny,  e.v.deny);
                check(e.tag, "plain", rsp_plain, e.v.plain);
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        line_tag_t l;
        who_t      w;

        // Reset holds outputs low despite an active lookup (R1)
        req_valid = 1'b1; tag_match = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "valid", rsp_valid, 0);
        check("R1", "hit",   rsp_hit,   0);
        check("R1", "plain", rsp_plain, 0);
        req_valid = 1'b0;
        rst = 1'b0;

        // Unsealed lines: tag compare alone (R3, R4)
        l = '{sealed: 1'b0, plain: 1'b0, ctx: 7'd3, pid: 6'd4, vm: 6'd2, vis: '0};
        w = '{hyp: 1'b1, kern: 1'b0, vm: 6'd9, pid: 6'd1, ctx: 7'd1};
        issue(l, w, 1'b1, 1'b0, 32'h40, "R3");
        issue(l, w, 1'b0, 1'b0, 32'h40, "R4");
        idle("R2");

        // Application owns the line (R5, R10)
        l = '{sealed: 1'b1, plain: 1'b1, ctx: 7'd5, pid: 6'd7, vm: 6'd2, vis: '0};
        w = '{hyp: 1'b0, kern: 1'b0, vm: 6'd2, pid: 6'd7, ctx: 7'd5};
        issue(l, w, 1'b1, 1'b0, 32'h100, "R5");
        l.plain = 1'b0;
        issue(l, w, 1'b1, 1'b0, 32'h100, "R10");

        // Foreign sealed space, with and without a shared key (R6)
        l = '{sealed: 1'b1, plain: 1'b1, ctx: 7'd6, pid: 6'd8, vm: 6'd2, vis: '1};
        issue(l, w, 1'b1, 1'b1, 32'h200, "R6");
        l.plain = 1'b0;
        issue(l, w, 1'b1, 1'b0, 32'h200, "R6");
        idle("R2");

        // Guest kernel on its own sealed space (R7)
        l = '{sealed: 1'b1, plain: 1'b1, ctx: 7'd11, pid: 6'd0, vm: 6'd3, vis: '0};
        w = '{hyp: 1'b0, kern: 1'b1, vm: 6'd3, pid: 6'd0, ctx: 7'd11};
        issue(l, w, 1'b1, 1'b0, 32'h0, "R7");

        // Guest kernel on an application line: word 5 visible or not (R8)
        l = '{sealed: 1'b1, plain: 1'b1, ctx: 7'd20, pid: 6'd9, vm: 6'd3, vis: 16'h0020};
        issue(l, w, 1'b1, 1'b0, 32'h0000_0014, "R8");
        l.vis = 16'hFFDF;
        issue(l, w, 1'b1, 1'b0, 32'h0000_0014, "R8");
        l.plain = 1'b0;
        issue(l, w, 1'b1, 1'b0, 32'h0000_0017, "R8");

        // Hypervisor always gets ciphertext (R9, R10)
        l = '{sealed: 1'b1, plain: 1'b0, ctx: 7'd11, pid: 6'd0, vm: 6'd3, vis: '1};
        w = '{hyp: 1'b1, kern: 1'b1, vm: 6'd3, pid: 6'd0, ctx: 7'd11};
        issue(l, w, 1'b1, 1'b1, 32'h10, "R9");
        l.plain = 1'b1;
        issue(l, w, 1'b1, 1'b1, 32'h10, "R10");

        // Sealed entitled line but no tag match (R4)
        l = '{sealed: 1'b1, plain: 1'b1, ctx: 7'd5, pid: 6'd7, vm: 6'd2, vis: '0};
        w = '{hyp: 1'b0, kern: 1'b0, vm: 6'd2, pid: 6'd7, ctx: 7'd5};
        issue(l, w, 1'b0, 1'b0, 32'h100, "R4");
        idle("R2");
        idle("R2");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule